// File: doc/BRIEF.md
# ADC Control and Status Register Bank

This block is the software-facing front of an analog-to-digital converter controller that converts one input channel at a time. A host reaches it over a simple 32-bit word bus: one request per cycle on `bus_valid`, with `bus_write` selecting the direction. Read data is combinational and valid in the same cycle as the request. Any side effect of a read, such as clearing a flag, takes place at the clock edge that ends the request. The block keeps the channel selection, the configuration and control words, the result and the completion flags. It drives a separate conversion sequencer through a start pulse, a channel code and the mode bits.

The sequencer returns its results through single-cycle strobes: `seq_done` with `seq_result`, and `seq_cal_done` with `seq_cal_fail`. These inputs have no ready signal. The block accepts every strobe in the cycle it arrives, so the sequencer never waits, and a strobe the block does not expect is dropped. A channel code of all ones (0x1F) does not select an input; it means "stopped". Calibration is requested through a self-clearing bit and finishes with a pass or fail report. Software builds on this map: it writes a channel to convert, waits for the interrupt, reads the result, and can run conversions back to back or start a calibration.

Top module: `adcreg_top`

## Requirements
- R1: After reset the channel control word at 0x00 reads 0x1F, with the interrupt enable (bit 7) clear. Status (0x08), general status (0x1C) and general control (0x18) read 0, and `irq`, `conv_start` and `cal_req` are low.
- R2: A write to 0x00 with a code in bits [4:0] other than 0x1F drives `conv_start` high for exactly the one cycle after the write edge, with `conv_chan` equal to the code. A write of code 0x1F starts nothing and stops any running conversion.
- R3: A `seq_done` strobe that arrives while a conversion is active stores `seq_result` in bits [11:0] of 0x0C and sets status bit 0. A strobe with no active conversion changes neither.
- R4: A read of 0x0C clears status bit 0 at the end of that read. A completion in the same cycle keeps the flag set.
- R5: `irq` is high exactly when status bit 0 and channel control bit 7 are both set.
- R6: When configuration bit 16 is 1, a new result replaces an unread one. When it is 0, the unread result is kept and the new one is dropped.
- R7: When general control bit 6 (continuous) is set, each accepted completion issues a new `conv_start` on the same channel in the next cycle. Once bit 6 is clear, the next completion ends the run without a restart.
- R8: Writing 1 to general control bit 7 while the code is 0x1F, bit 7 of 0x00 is set and no conversion is active starts a calibration. Bit 7 reads 1 and `cal_req` stays high until `seq_cal_done`. After that strobe, bit 7 clears, general status bit 1 takes the value of `seq_cal_fail`, and status bit 0 sets.
- R9: A calibration request made under any other condition is refused: bit 7 reads 0 and `cal_req` stays low.
- R10: An access at an offset that is not a multiple of 4, or that is above 0x30, reads 0 and changes no state.
- R11: These words read back as written, masked: configuration 0x14 [16:0], general control 0x18 [6:0], offset 0x24 [15:0], calibration 0x28 [15:0], pin control 0x30 [31:0] and channel control 1 at 0x04 [7:0]. Offset 0x10 reads 0. The outputs follow these fields: `conv_res` from 0x14 [3:2], `conv_avg_en` from 0x18 bit 5 and `conv_cont` from 0x18 bit 6.
- R12: While a calibration runs, writes to 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Completion interrupt |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | CH_W | Selected channel code |
| conv_res | output | 2 | Resolution mode field |
| conv_avg_en | output | 1 | Hardware averaging enable |
| conv_cont | output | 1 | Continuous conversion mode |
| cal_req | output | 1 | Calibration in progress |
| seq_done | input | 1 | Conversion finished strobe |
| seq_result | input | RES_W | Conversion result |
| seq_cal_done | input | 1 | Calibration finished strobe |
| seq_cal_fail | input | 1 | Calibration outcome, 1 = fail |

## Verification
The bench uses the default parameters: an 8-bit address, 12-bit results and 5-bit channel codes. The 8-bit address reaches offsets above 0x30 and misaligned offsets, so the ignore rule can be exercised. The full 12-bit result field appears at 0x0C, so truncation or shifting of results would show. The 5-bit code makes 0x1F the stop value, and the bench tests it against ordinary channels both for starting conversions and for gating calibration.

// File: rtl/adcreg_pkg.sv
package adcreg_pkg;
  localparam int OFS_CHC0  = 'h00;
  localparam int OFS_CHC1  = 'h04;
  localparam int OFS_STAT  = 'h08;
  localparam int OFS_RES0  = 'h0C;
  localparam int OFS_RES1  = 'h10;
  localparam int OFS_CONF  = 'h14;
  localparam int OFS_GCTL  = 'h18;
  localparam int OFS_GSTAT = 'h1C;
  localparam int OFS_OFFS  = 'h24;
  localparam int OFS_CALV  = 'h28;
  localparam int OFS_PINC  = 'h30;
  localparam int OFS_LAST  = OFS_PINC;

  localparam int CH_IE_BIT   = 7;
  localparam int GC_AVG_BIT  = 5;
  localparam int GC_CONT_BIT = 6;
  localparam int GC_CAL_BIT  = 7;
  localparam int CF_OVW_BIT  = 16;
  localparam int CONF_W      = 17;

  typedef struct packed {
    logic chc0;
    logic chc1;
    logic stat;
    logic res0;
    logic res1;
    logic conf;
    logic gctl;
    logic gstat;
    logic offs;
    logic calv;
    logic pinc;
  } adcreg_sel_t;
endpackage

// File: rtl/adcreg_decode.sv
module adcreg_decode
  import adcreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output adcreg_sel_t       sel,
  output logic              addr_ok
);
  always_comb begin
    sel     = '0;
    addr_ok = (addr[1:0] == 2'b00) && (addr <= ADDR_W'(OFS_LAST));
    if (addr_ok) begin
      case (addr)
        ADDR_W'(OFS_CHC0):  sel.chc0  = 1'b1;
        ADDR_W'(OFS_CHC1):  sel.chc1  = 1'b1;
        ADDR_W'(OFS_STAT):  sel.stat  = 1'b1;
        ADDR_W'(OFS_RES0):  sel.res0  = 1'b1;
        ADDR_W'(OFS_RES1):  sel.res1  = 1'b1;
        ADDR_W'(OFS_CONF):  sel.conf  = 1'b1;
        ADDR_W'(OFS_GCTL):  sel.gctl  = 1'b1;
        ADDR_W'(OFS_GSTAT): sel.gstat = 1'b1;
        ADDR_W'(OFS_OFFS):  sel.offs  = 1'b1;
        ADDR_W'(OFS_CALV):  sel.calv  = 1'b1;
        ADDR_W'(OFS_PINC):  sel.pinc  = 1'b1;
        default:            sel       = '0;
      endcase
    end
  end
endmodule

// File: rtl/adcreg_result.sv
module adcreg_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] res_in,
  input  logic             cal_fin,
  input  logic             ovw_en,
  input  logic             rd_clr,
  output logic             flag,
  output logic [RES_W-1:0] res_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      res_q <= '0;
    end else begin
      if (load && (!flag || ovw_en)) res_q <= res_in;
      if (load || cal_fin)           flag  <= 1'b1;
      else if (rd_clr)               flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/adcreg_ctrl.sv
module adcreg_ctrl
  import adcreg_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_chc0,
  input  logic            wr_gctl,
  input  logic [7:0]      wdata,
  input  logic            seq_done,
  input  logic            seq_cal_done,
  input  logic            seq_cal_fail,
  output logic [CH_W-1:0] ch_code,
  output logic            ch_ie,
  output logic [7:0]      gctl_q,
  output logic            calf,
  output logic            conv_start,
  output logic            load,
  output logic            cal_fin
);
  localparam logic [CH_W-1:0] STOP = {CH_W{1'b1}};

  logic active, cal_busy, chc_take, code_ok, cal_grant, restart;

  assign cal_busy  = gctl_q[GC_CAL_BIT];
  assign chc_take  = wr_chc0 && !cal_busy;
  assign code_ok   = wdata[CH_W-1:0] != STOP;
  assign load      = seq_done && active;
  assign cal_fin   = seq_cal_done && cal_busy;
  assign restart   = load && gctl_q[GC_CONT_BIT] && (ch_code != STOP);
  assign cal_grant = wr_gctl && wdata[GC_CAL_BIT] && !cal_busy &&
                     (ch_code == STOP) && ch_ie && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_code    <= STOP;
      ch_ie      <= 1'b0;
      active     <= 1'b0;
      conv_start <= 1'b0;
      gctl_q     <= '0;
      calf       <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (chc_take) begin
        ch_code    <= wdata[CH_W-1:0];
        ch_ie      <= wdata[CH_IE_BIT];
        active     <= code_ok;
        conv_start <= code_ok;
      end else if (load) begin
        active     <= restart;
        conv_start <= restart;
      end
      if (wr_gctl) gctl_q[6:0] <= wdata[6:0];
      if (cal_fin)        gctl_q[GC_CAL_BIT] <= 1'b0;
      else if (cal_grant) gctl_q[GC_CAL_BIT] <= 1'b1;
      if (cal_grant)    calf <= 1'b0;
      else if (cal_fin) calf <= seq_cal_fail;
    end
  end
endmodule

// File: rtl/adcreg_top.sv
module adcreg_top
  import adcreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RES_W  = 12,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic [1:0]        conv_res,
  output logic              conv_avg_en,
  output logic              conv_cont,
  output logic              cal_req,
  input  logic              seq_done,
  input  logic [RES_W-1:0]  seq_result,
  input  logic              seq_cal_done,
  input  logic              seq_cal_fail
);
  adcreg_sel_t      sel;
  logic             addr_ok, wr, rd;
  logic [CH_W-1:0]  ch_code;
  logic             ch_ie, calf, done_flag, load, cal_fin;
  logic [7:0]       gctl_q, chc1_q;
  logic [RES_W-1:0] res_q;
  logic [CONF_W-1:0] conf_q;
  logic [15:0]      offs_q, calv_q;
  logic [31:0]      pinc_q;

  assign wr = bus_valid && bus_write && addr_ok;
  assign rd = bus_valid && !bus_write && addr_ok;

  adcreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel), .addr_ok(addr_ok)
  );

  adcreg_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_chc0(wr && sel.chc0), .wr_gctl(wr && sel.gctl),
    .wdata(bus_wdata[7:0]),
    .seq_done(seq_done), .seq_cal_done(seq_cal_done), .seq_cal_fail(seq_cal_fail),
    .ch_code(ch_code), .ch_ie(ch_ie), .gctl_q(gctl_q), .calf(calf),
    .conv_start(conv_start), .load(load), .cal_fin(cal_fin)
  );

  adcreg_result #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .load(load), .res_in(seq_result), .cal_fin(cal_fin),
    .ovw_en(conf_q[CF_OVW_BIT]), .rd_clr(rd && sel.res0),
    .flag(done_flag), .res_q(res_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chc1_q <= '0;
      conf_q <= '0;
      offs_q <= '0;
      calv_q <= '0;
      pinc_q <= '0;
    end else if (wr) begin
      if (sel.chc1) chc1_q <= bus_wdata[7:0];
      if (sel.conf) conf_q <= bus_wdata[CONF_W-1:0];
      if (sel.offs) offs_q <= bus_wdata[15:0];
      if (sel.calv) calv_q <= bus_wdata[15:0];
      if (sel.pinc) pinc_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (1'b1)
        sel.chc0:  bus_rdata = 32'(ch_code) | (32'(ch_ie) << CH_IE_BIT);
        sel.chc1:  bus_rdata = 32'(chc1_q);
        sel.stat:  bus_rdata = 32'(done_flag);
        sel.res0:  bus_rdata = 32'(res_q);
        sel.conf:  bus_rdata = 32'(conf_q);
        sel.gctl:  bus_rdata = 32'(gctl_q);
        sel.gstat: bus_rdata = 32'(calf) << 1;
        sel.offs:  bus_rdata = 32'(offs_q);
        sel.calv:  bus_rdata = 32'(calv_q);
        sel.pinc:  bus_rdata = pinc_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq         = done_flag && ch_ie;
  assign conv_chan   = ch_code;
  assign conv_res    = conf_q[3:2];
  assign conv_avg_en = gctl_q[GC_AVG_BIT];
  assign conv_cont   = gctl_q[GC_CONT_BIT];
  assign cal_req     = gctl_q[GC_CAL_BIT];
endmodule

// File: rtl/adcreg_chk.sv
module adcreg_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic            irq,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            cal_req,
  input logic            seq_done,
  input logic            seq_cal_done,
  input logic            ie,
  input logic            flag
);
  localparam logic [CH_W-1:0] STOP = {CH_W{1'b1}};

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !seq_done && !(bus_valid && bus_write)) |=> !conv_start);
  a_r2_start_not_stop: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_chan != STOP));
  a_r8_cal_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> !conv_start);
  a_r8_cal_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && !seq_cal_done) |=> cal_req);
  a_r3_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(seq_done || seq_cal_done));
endmodule

bind adcreg_top adcreg_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan), .cal_req(cal_req),
  .seq_done(seq_done), .seq_cal_done(seq_cal_done), .ie(ch_ie), .flag(done_flag)
);

// File: tb/tb_adcreg_top.sv
module tb_adcreg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, conv_start, conv_avg_en, conv_cont, cal_req;
  logic [4:0]  conv_chan;
  logic [1:0]  conv_res;
  logic        seq_done = 1'b0, seq_cal_done = 1'b0, seq_cal_fail = 1'b0;
  logic [11:0] seq_result = '0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  adcreg_top dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan), .conv_res(conv_res),
    .conv_avg_en(conv_avg_en), .conv_cont(conv_cont), .cal_req(cal_req),
    .seq_done(seq_done), .seq_result(seq_result),
    .seq_cal_done(seq_cal_done), .seq_cal_fail(seq_cal_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic finish_conv(input logic [11:0] v);
    @(negedge clk);
    seq_done = 1'b1; seq_result = v;
    @(negedge clk);
    seq_done = 1'b0;
  endtask

  task automatic finish_cal(input logic f);
    @(negedge clk);
    seq_cal_done = 1'b1; seq_cal_fail = f;
    @(negedge clk);
    seq_cal_done = 1'b0; seq_cal_fail = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 chc0", 8'h00, 32'h1F);
    rd_chk("R1 stat", 8'h08, 32'h0);
    rd_chk("R1 gstat", 8'h1C, 32'h0);
    rd_chk("R1 gctl", 8'h18, 32'h0);
    chk("R1 irq", irq, 0);
    chk("R1 start", conv_start, 0);
    chk("R1 cal_req", cal_req, 0);
  endtask

  task automatic t_single;
    wr(8'h00, 32'h83);
    chk("R2 start high", conv_start, 1);
    chk("R2 chan", conv_chan, 3);
    @(negedge clk);
    chk("R2 start one cycle", conv_start, 0);
    finish_conv(12'hABC);
    chk("R5 irq set", irq, 1);
    rd_chk("R3 stat set", 8'h08, 32'h1);
    rd_chk("R3 result", 8'h0C, 32'hABC);
    rd_chk("R4 stat cleared", 8'h08, 32'h0);
    chk("R5 irq clear", irq, 0);
  endtask

  task automatic t_stop_code;
    wr(8'h00, 32'h9F);
    chk("R2 stop no start", conv_start, 0);
    finish_conv(12'h111);
    rd_chk("R3 stray done ignored stat", 8'h08, 32'h0);
    rd_chk("R3 stray done ignored result", 8'h0C, 32'hABC);
  endtask

  task automatic t_irq_mask;
    wr(8'h00, 32'h05);
    finish_conv(12'h055);
    chk("R5 masked irq", irq, 0);
    rd_chk("R5 flag still set", 8'h08, 32'h1);
    rd_chk("R3 masked result", 8'h0C, 32'h055);
  endtask

  task automatic t_overwrite;
    wr(8'h14, 32'h10000);
    wr(8'h00, 32'h02); finish_conv(12'h100);
    wr(8'h00, 32'h02); finish_conv(12'h200);
    rd_chk("R6 overwrite on", 8'h0C, 32'h200);
    wr(8'h14, 32'h0);
    wr(8'h00, 32'h02); finish_conv(12'h300);
    wr(8'h00, 32'h02); finish_conv(12'h400);
    rd_chk("R6 overwrite off keeps", 8'h0C, 32'h300);
    rd_chk("R4 flag cleared", 8'h08, 32'h0);
  endtask

  task automatic t_cont;
    wr(8'h18, 32'h40);
    chk("R11 conv_cont", conv_cont, 1);
    wr(8'h00, 32'h84);
    chk("R7 first start", conv_start, 1);
    finish_conv(12'h010);
    chk("R7 restart", conv_start, 1);
    chk("R7 same chan", conv_chan, 4);
    rd_chk("R7 first result", 8'h0C, 32'h010);
    wr(8'h18, 32'h00);
    finish_conv(12'h020);
    chk("R7 no restart", conv_start, 0);
    finish_conv(12'h030);
    rd_chk("R7 run ended", 8'h0C, 32'h020);
  endtask

  task automatic t_cal_refused;
    wr(8'h18, 32'h80);
    chk("R9 refused chan", cal_req, 0);
    rd_chk("R9 bit clear chan", 8'h18, 32'h0);
    wr(8'h00, 32'h1F);
    wr(8'h18, 32'h80);
    chk("R9 refused ie", cal_req, 0);
    rd_chk("R9 bit clear ie", 8'h18, 32'h0);
  endtask

  task automatic t_cal;
    wr(8'h00, 32'h9F);
    wr(8'h18, 32'h80);
    chk("R8 cal_req", cal_req, 1);
    rd_chk("R8 bit reads 1", 8'h18, 32'h80);
    wr(8'h00, 32'h83);
    chk("R12 no start", conv_start, 0);
    rd_chk("R12 chc0 kept", 8'h00, 32'h9F);
    finish_cal(1'b1);
    chk("R8 cal_req drop", cal_req, 0);
    chk("R8 irq", irq, 1);
    rd_chk("R8 bit self-clear", 8'h18, 32'h0);
    rd_chk("R8 fail flag", 8'h1C, 32'h2);
    rd_chk("R8 stat", 8'h08, 32'h1);
    rd_chk("R4 clear after cal", 8'h0C, 32'h020);
    wr(8'h18, 32'h80);
    finish_cal(1'b0);
    rd_chk("R8 pass flag", 8'h1C, 32'h0);
    rd_chk("R8 stat pass", 8'h08, 32'h1);
  endtask

  task automatic t_storage;
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R11 conf", 8'h14, 32'h1FFFF);
    chk("R11 conv_res", conv_res, 3);
    wr(8'h24, 32'hFFFF_FFFF);
    rd_chk("R11 offs", 8'h24, 32'hFFFF);
    wr(8'h28, 32'h1234_5678);
    rd_chk("R11 calv", 8'h28, 32'h5678);
    wr(8'h30, 32'hDEAD_BEEF);
    rd_chk("R11 pinc", 8'h30, 32'hDEAD_BEEF);
    wr(8'h04, 32'h1FF);
    rd_chk("R11 chc1", 8'h04, 32'hFF);
    rd_chk("R11 res1 zero", 8'h10, 32'h0);
    wr(8'h18, 32'h3F);
    rd_chk("R11 gctl", 8'h18, 32'h3F);
    chk("R11 avg", conv_avg_en, 1);
    wr(8'h18, 32'h0);
    wr(8'h14, 32'h0000C);
  endtask

  task automatic t_bad_addr;
    wr(8'h15, 32'h0);
    rd_chk("R10 misaligned write ignored", 8'h14, 32'hC);
    rd_chk("R10 misaligned read zero", 8'h15, 32'h0);
    wr(8'h34, 32'hFFFF);
    rd_chk("R10 high read zero", 8'h34, 32'h0);
    wr(8'h01, 32'h83);
    chk("R10 no start", conv_start, 0);
    rd_chk("R10 chc0 kept", 8'h00, 32'h9F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_stop_code();
    t_irq_mask();
    t_overwrite();
    t_cont();
    t_cal_refused();
    t_cal();
    t_storage();
    t_bad_addr();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule